// File: doc/BRIEF.md
# Decode-Stage Branch Resolver with Per-Branch Slot Policy

This block chooses the next fetch address for a five-stage pipeline that tests branch conditions in decode, and decides whether the instruction fetched just after a branch survives. That instruction is the delay slot. A branch in decode is tested by checking one register operand against zero. When the branch is taken, the fetch address moves to the target on the next clock edge, so a taken branch costs one slot and not three. The block holds the program counter and the valid bit of the decode-stage register. A slot that is annulled becomes a NOP because its valid bit is cleared on the clock edge that loads it into decode.

Each branch carries its own slot policy. A delayed branch always keeps its slot. A conventional branch discards the slot when it is taken. A canceling branch keeps the slot only when it is taken. The zero test cannot use the execute-stage bypass. If the instruction now in execute writes the register that the branch tests, the block asserts a stall. While the stall holds, the branch stays unresolved, the fetch address is held and the decode register keeps its contents.

Top module: `br_slot_ctl`

## Requirements
- R1: While `rst` is high, `fetch_pc` equals the parameter `RESET_PC` and `id_valid` is 0. The first edge after `rst` is released moves `fetch_pc` to `RESET_PC`+4 and sets `id_valid` to 1.
- R2: When decode holds no valid branch, `fetch_pc` advances by `STEP` (default 4) on each edge, and `annul` and `br_taken` stay 0.
- R3: The encoding of `dec_kind` is 0 = no branch, 1 = delayed, 2 = conventional, 3 = canceling. A branch with `dec_on_nz`=0 is taken when `dec_operand` is zero, and one with `dec_on_nz`=1 is taken when it is nonzero. A resolved taken branch raises `br_taken`, and the next edge loads `dec_target` into `fetch_pc`.
- R4: A delayed branch never raises `annul`, whatever its outcome.
- R5: A conventional branch raises `annul` exactly when it is resolved taken.
- R6: A canceling branch raises `annul` exactly when it is resolved not taken.
- R7: On the edge after a cycle with `annul`=1 without a stall, `id_valid` becomes 0, which turns the slot into a NOP. On the edge after any other cycle without a stall, `id_valid` becomes 1.
- R8: A stall occurs when decode holds a valid branch, `ex_wr_en` is 1 and `ex_wr_reg` equals a nonzero `dec_src_reg`. During a stall `br_taken` and `annul` are 0, and `fetch_pc` and `id_valid` keep their values across the edge.
- R9: A write to register 0, a write to a different register, or a non-branch instruction in decode never raises `stall`.
- R10: A resolved branch that is not taken advances `fetch_pc` by `STEP` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_kind | input | 2 | Branch kind of the instruction in decode (0 none, 1 delayed, 2 conventional, 3 canceling) |
| dec_on_nz | input | 1 | 0: taken when operand is zero; 1: taken when operand is nonzero |
| dec_operand | input | XLEN | Register value under test |
| dec_src_reg | input | RAW | Index of the register under test |
| dec_target | input | XLEN | Branch target address |
| ex_wr_en | input | 1 | Instruction in execute writes a register |
| ex_wr_reg | input | RAW | Destination register of the instruction in execute |
| fetch_pc | output | XLEN | Address being fetched this cycle |
| id_valid | output | 1 | Valid bit of the decode-stage register |
| stall | output | 1 | Operand hazard: hold fetch and decode |
| br_taken | output | 1 | Branch in decode resolved taken this cycle |
| annul | output | 1 | Slot instruction is discarded at the next edge |

## Verification
The assertions check, on every cycle, the behaviour that follows directly from the register update. A stall must hold the fetch address and the decode valid bit. A redirect must load the target. A cycle that neither stalls nor redirects must advance the address by one step. An annul must clear the valid bit, a delayed branch must never annul, and a stall must block resolution. Other properties can only be shown by the bench's scenarios. These are the three policies under both outcomes, the two polarities of the zero test, the register-0 and mismatched-register cases of the hazard check, and the full sequence of fetch addresses. The bench compares each of these with a reference model of its own.

// File: rtl/brslot_pkg.sv
package brslot_pkg;

    typedef enum logic [1:0] {
        BK_NONE    = 2'd0,
        BK_DELAYED = 2'd1,
        BK_CONV    = 2'd2,
        BK_CANCEL  = 2'd3
    } br_kind_e;

    typedef struct packed {
        logic resolve;
        logic taken;
        logic annul;
    } br_verdict_t;

    // Zero test with selectable polarity.
    function automatic logic zero_test(input logic on_nz, input logic is_zero);
        return on_nz ? !is_zero : is_zero;
    endfunction

    // Whether the slot instruction must be discarded for this kind and outcome.
    function automatic logic slot_dies(input br_kind_e kind, input logic taken);
        case (kind)
            BK_CONV:   return taken;
            BK_CANCEL: return !taken;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/br_hazard.sv
module br_hazard #(
    parameter int RAW = 5
) (
    input  logic           id_valid,
    input  logic           is_branch,
    input  logic [RAW-1:0] src_reg,
    input  logic           ex_wr_en,
    input  logic [RAW-1:0] ex_wr_reg,
    output logic           stall
);
    localparam logic [RAW-1:0] ZERO_REG = '0;

    logic match;

    always_comb begin
        match = ex_wr_en && (ex_wr_reg == src_reg) && (src_reg != ZERO_REG);
        stall = id_valid && is_branch && match;
    end

endmodule

// File: rtl/br_eval.sv
module br_eval
    import brslot_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              id_valid,
    input  br_kind_e          kind,
    input  logic              on_nz,
    input  logic [XLEN-1:0]   operand,
    input  logic              stall,
    output br_verdict_t       verdict
);
    logic is_zero;
    logic cond;

    always_comb begin
        is_zero         = (operand == '0);
        cond            = zero_test(on_nz, is_zero);
        verdict.resolve = id_valid && (kind != BK_NONE) && !stall;
        verdict.taken   = verdict.resolve && cond;
        verdict.annul   = verdict.resolve && slot_dies(kind, cond);
    end

    // R8
    stall_noresolve_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> (!verdict.taken && !verdict.annul));

    // R4
    delayed_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (id_valid && kind == BK_DELAYED) |-> !verdict.annul);

endmodule

// File: rtl/br_pcreg.sv
module br_pcreg #(
    parameter int              XLEN     = 32,
    parameter int              STEP     = 4,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stall,
    input  logic            redirect,
    input  logic [XLEN-1:0] target,
    input  logic            annul,
    output logic [XLEN-1:0] pc_q,
    output logic            id_valid_q
);
    localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

    logic [XLEN-1:0] pc_d;
    logic            valid_d;

    always_comb begin
        if (stall) begin
            pc_d    = pc_q;
            valid_d = id_valid_q;
        end else begin
            pc_d    = redirect ? target : pc_q + STEP_V;
            valid_d = !annul;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q       <= RESET_PC;
            id_valid_q <= 1'b0;
        end else begin
            pc_q       <= pc_d;
            id_valid_q <= valid_d;
        end
    end

    // R8
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(pc_q));

    // R8
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(id_valid_q));

    // R3
    redirect_chk: assert property (@(posedge clk) disable iff (rst)
        (redirect && !stall) |=> (pc_q == $past(target)));

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!redirect && !stall) |=> (pc_q == $past(pc_q) + STEP_V));

    // R7
    annul_kill_chk: assert property (@(posedge clk) disable iff (rst)
        (annul && !stall) |=> !id_valid_q);

endmodule

// File: rtl/br_slot_ctl.sv
module br_slot_ctl
    import brslot_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              RAW      = 5,
    parameter int              STEP     = 4,
    parameter logic [XLEN-1:0] RESET_PC = 32'h0000_0100
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      dec_kind,
    input  logic            dec_on_nz,
    input  logic [XLEN-1:0] dec_operand,
    input  logic [RAW-1:0]  dec_src_reg,
    input  logic [XLEN-1:0] dec_target,
    input  logic            ex_wr_en,
    input  logic [RAW-1:0]  ex_wr_reg,
    output logic [XLEN-1:0] fetch_pc,
    output logic            id_valid,
    output logic            stall,
    output logic            br_taken,
    output logic            annul
);
    br_kind_e    kind;
    br_verdict_t verdict;
    logic        valid_q;
    logic        hz;

    assign kind = br_kind_e'(dec_kind);

    br_hazard #(.RAW(RAW)) u_hazard (
        .id_valid  (valid_q),
        .is_branch (kind != BK_NONE),
        .src_reg   (dec_src_reg),
        .ex_wr_en  (ex_wr_en),
        .ex_wr_reg (ex_wr_reg),
        .stall     (hz)
    );

    br_eval #(.XLEN(XLEN)) u_eval (
        .clk      (clk),
        .rst      (rst),
        .id_valid (valid_q),
        .kind     (kind),
        .on_nz    (dec_on_nz),
        .operand  (dec_operand),
        .stall    (hz),
        .verdict  (verdict)
    );

    br_pcreg #(.XLEN(XLEN), .STEP(STEP), .RESET_PC(RESET_PC)) u_pcreg (
        .clk        (clk),
        .rst        (rst),
        .stall      (hz),
        .redirect   (verdict.taken),
        .target     (dec_target),
        .annul      (verdict.annul),
        .pc_q       (fetch_pc),
        .id_valid_q (valid_q)
    );

    assign id_valid = valid_q;
    assign stall    = hz;
    assign br_taken = verdict.taken;
    assign annul    = verdict.annul;

endmodule

// File: tb/br_slot_ctl_test.sv
`timescale 1ns/100ps
module br_slot_ctl_test;
    localparam int          XLEN   = 32;
    localparam int          RAW    = 5;
    localparam logic [31:0] RST_PC = 32'h0000_0100;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      dec_kind = 2'd0;
    logic            dec_on_nz = 1'b0;
    logic [XLEN-1:0] dec_operand = '0;
    logic [RAW-1:0]  dec_src_reg = '0;
    logic [XLEN-1:0] dec_target = '0;
    logic            ex_wr_en = 1'b0;
    logic [RAW-1:0]  ex_wr_reg = '0;
    logic [XLEN-1:0] fetch_pc;
    logic            id_valid, stall, br_taken, annul;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_pc;
    logic        exp_v;

    always #2.5 clk = ~clk;

    br_slot_ctl #(.XLEN(XLEN), .RAW(RAW), .STEP(4), .RESET_PC(RST_PC)) uut (
        .clk(clk), .rst(rst), .dec_kind(dec_kind), .dec_on_nz(dec_on_nz),
        .dec_operand(dec_operand), .dec_src_reg(dec_src_reg), .dec_target(dec_target),
        .ex_wr_en(ex_wr_en), .ex_wr_reg(ex_wr_reg), .fetch_pc(fetch_pc),
        .id_valid(id_valid), .stall(stall), .br_taken(br_taken), .annul(annul)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic m_taken(input logic nz, input logic [31:0] op);
        return nz ? (op != 0) : (op == 0);
    endfunction

    function automatic logic m_dies(input logic [1:0] k, input logic tk);
        if (k == 2'd2) return tk;
        if (k == 2'd3) return !tk;
        return 1'b0;
    endfunction

    // Starts away from an edge; ends at the following negative edge.
    task automatic step(input logic [1:0] k, input logic nz, input logic [31:0] op,
                        input logic [31:0] tgt, input logic [4:0] src,
                        input logic wen, input logic [4:0] wreg);
        logic isbr, hz, res, tk, an;
        string ptag, atag;
        dec_kind = k; dec_on_nz = nz; dec_operand = op; dec_target = tgt;
        dec_src_reg = src; ex_wr_en = wen; ex_wr_reg = wreg;
        #1;
        isbr = exp_v && (k != 2'd0);
        hz   = isbr && wen && (wreg == src) && (src != 0);
        res  = isbr && !hz;
        tk   = res && m_taken(nz, op);
        an   = res && m_dies(k, m_taken(nz, op));
        atag = (k == 2'd1) ? "R4" : (k == 2'd2) ? "R5" : (k == 2'd3) ? "R6" : "R2";
        if (hz) atag = "R8";
        chk(hz ? "R8" : "R9", "stall", 32'(stall), 32'(hz));
        chk(atag, "annul", 32'(annul), 32'(an));
        chk(hz ? "R8" : "R3", "br_taken", 32'(br_taken), 32'(tk));
        ptag = hz ? "R8" : tk ? "R3" : isbr ? "R10" : "R2";
        if (!hz) begin
            exp_pc = tk ? tgt : exp_pc + 32'd4;
            exp_v  = !an;
        end
        @(posedge clk); #1;
        chk(ptag, "fetch_pc", fetch_pc, exp_pc);
        chk(hz ? "R8" : "R7", "id_valid", 32'(id_valid), 32'(exp_v));
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "fetch_pc", fetch_pc, RST_PC);
        chk("R1", "id_valid", 32'(id_valid), 32'd0);
        rst = 1'b0;
        exp_pc = RST_PC; exp_v = 1'b0;
        // R1: first edge after release
        step(2'd0, 0, 0, 0, 0, 0, 0);
        chk("R1", "first pc", fetch_pc, RST_PC + 32'd4);
        step(2'd0, 0, 0, 0, 0, 0, 0);
        // R4 delayed: taken, then not taken
        step(2'd1, 0, 0, 32'h2000, 5'd3, 0, 0);
        step(2'd1, 1, 0, 32'h2100, 5'd3, 0, 0);
        // R5 conventional: taken annuls, then slot decoded invalid
        step(2'd2, 1, 32'h5, 32'h3000, 5'd4, 0, 0);
        step(2'd2, 0, 32'h5, 32'h3100, 5'd4, 0, 0); // masked: decode invalid
        step(2'd2, 0, 32'h5, 32'h3200, 5'd4, 0, 0); // R10 not taken
        // R6 canceling: not taken annuls, taken keeps
        step(2'd3, 0, 32'h9, 32'h4000, 5'd6, 0, 0);
        step(2'd0, 0, 0, 0, 0, 0, 0);
        step(2'd3, 0, 32'h0, 32'h4400, 5'd6, 0, 0);
        // R8 hazard stall twice, then resolve
        step(2'd2, 0, 32'h0, 32'h5000, 5'd7, 1, 5'd7);
        step(2'd2, 0, 32'h0, 32'h5000, 5'd7, 1, 5'd7);
        step(2'd2, 0, 32'h0, 32'h5000, 5'd7, 0, 5'd7);
        step(2'd0, 0, 0, 0, 0, 0, 0);
        // R9 register 0 and mismatched register never stall
        step(2'd1, 0, 32'h0, 32'h6000, 5'd0, 1, 5'd0);
        step(2'd1, 0, 32'h1, 32'h6100, 5'd8, 1, 5'd9);
        step(2'd0, 0, 32'h1, 32'h6100, 5'd8, 1, 5'd8);
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic [1:0]  k;
            logic [31:0] op;
            logic [4:0]  s, w;
            k  = 2'($urandom % 4);
            op = ($urandom % 2) ? 32'h0 : $urandom;
            s  = 5'($urandom % 4);
            w  = 5'($urandom % 4);
            step(k, 1'($urandom % 2), op, {$urandom} & 32'hFFFF_FFFC, s,
                 ($urandom % 3) == 0, w);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule